// File: doc/BRIEF.md
# Dual-Channel Conversion Sequencer

This block steps one shared converter core through two channel conversions for each start command. A start request seen while the block is idle raises a busy flag. Channel A is converted first, then channel B. A one-cycle active-low end-of-conversion strobe marks the end of each channel conversion. Once both results exist, a latch strobe copies them into the output word, and busy falls in the same cycle that the new word appears. The falling edge of busy therefore serves as the data-ready indication.

A power-down input stops new pairs from starting but never cuts a pair short. A synchronous active-low reset aborts any pair in flight and clears the output word. The converter core is a counter stub. It takes a fixed number of cycles per channel and returns the digital sample that was presented for the selected channel.

Top module: `conv_pair_sequencer`

## Requirements
- R1: When start_i is high at a rising edge while the block is idle, busy_o is high after that edge, and core_go_o pulses for channel A (core_ch_o = 0) at the same time. Call that edge "edge 0".
- R2: busy_o stays high after edges 0 through 2*CONV_CYCLES+4, which is 2*CONV_CYCLES+5 cycles. It is low after edge 2*CONV_CYCLES+5.
- R3: The output word is {channel A result, channel B result}, with channel A in bits [2*DATA_W-1:DATA_W]. Each result equals the sample on samp_a_i or samp_b_i. Samples must be held stable while busy_o is high.
- R4: eoc_n_o goes low exactly twice per busy window. Each low pulse lasts one cycle. The first appears after edge CONV_CYCLES+2 (channel A done). The second appears after edge 2*CONV_CYCLES+4 (channel B done).
- R5: A start request while busy_o is high is ignored. This includes a request in the final busy cycle. Such a request neither lengthens the busy window nor adds strobes.
- R6: While pdown_i is high and the block is idle, start_i has no effect. busy_o stays low and result_o keeps its value.
- R7: If pdown_i rises during a pair, that pair completes with normal timing and a correct result. Starts are then refused while pdown_i stays high.
- R8: After reset, busy_o=0, eoc_n_o=1, latch_o=0 and result_o=0. A reset during a pair aborts it: no strobe or latch follows, and result_o stays 0.
- R9: With start_i held high, busy_o is low for exactly one cycle between consecutive pairs.
- R10: latch_o pulses for one cycle, after edge 2*CONV_CYCLES+4. result_o changes only after the next edge, together with the fall of busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request for a pair of conversions |
| pdown_i | input | 1 | Power-down: refuses new starts |
| samp_a_i | input | DATA_W | Digital stand-in for channel A input |
| samp_b_i | input | DATA_W | Digital stand-in for channel B input |
| busy_o | output | 1 | High while a pair is in progress |
| eoc_n_o | output | 1 | Active-low one-cycle end-of-conversion per channel |
| latch_o | output | 1 | One-cycle strobe loading the output word |
| core_go_o | output | 1 | Start pulse to the converter core |
| core_ch_o | output | 1 | Channel selected for the core (0 = A, 1 = B) |
| result_o | output | 2*DATA_W | Latched pair of results, channel A high |

## Verification
The pair sequence is run with distinct sample pairs, such as 0x1234/0xABCD, all-ones/zero and zero/all-ones. These patterns expose swapped channel order or a lost half-word. Start requests are injected early in a window and in its last busy cycle, which separates a correct ignore from an off-by-one in the commit state. Power-down is applied both while idle and during a pair, to tell "refuse to start" apart from "abort". A held start and a mid-pair reset check the one-cycle idle gap and the clean abort with no late strobes.

// File: rtl/conv_seq_pkg.sv
// Shared types for the dual-channel conversion sequencer.
// Assumes: exactly two channels, converted in fixed order A then B.
package conv_seq_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CONV_A,
        SEQ_CONV_B,
        SEQ_COMMIT
    } seq_state_e;
endpackage

// File: rtl/conv_core_stub.sv
// Converter core model: on a go pulse it captures the selected channel
// sample and, CONV_CYCLES cycles later, raises done for one cycle.
// Assumes: go only arrives while the core is idle; CONV_CYCLES >= 2.
module conv_core_stub #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              ch_i,
    input  logic [DATA_W-1:0] samp_a_i,
    input  logic [DATA_W-1:0] samp_b_i,
    output logic              done_o,
    output logic [DATA_W-1:0] res_o
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

    logic [DATA_W-1:0] samp_sel [conv_seq_pkg::NUM_CH];
    logic [CNT_W-1:0]  cnt_q;
    logic              running_q;

    // Collect the channel samples into an indexable array.
    generate
        for (genvar g = 0; g < conv_seq_pkg::NUM_CH; g++) begin : g_samp
            if (g == 0) begin : g_a
                assign samp_sel[g] = samp_a_i;
            end else begin : g_b
                assign samp_sel[g] = samp_b_i;
            end
        end
    endgenerate

    // Count down the conversion time and pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            done_o    <= 1'b0;
            res_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                running_q <= 1'b1;
                cnt_q     <= CNT_W'(CONV_CYCLES - 1);
                res_o     <= samp_sel[ch_i];
            end else if (running_q) begin
                if (cnt_q == '0) begin
                    running_q <= 1'b0;
                    done_o    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !running_q); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
endmodule

// File: rtl/conv_seq_fsm.sv
// Pair sequencer: starts channel A, then channel B, strobes end-of-conversion
// for each, then requests the output latch and drops busy.
// Assumes: core_done_i is a single-cycle pulse; core_res_i holds until next go.
module conv_seq_fsm #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pdown_i,
    input  logic              core_done_i,
    input  logic [DATA_W-1:0] core_res_i,
    output logic              busy_o,
    output logic              eoc_n_o,
    output logic              latch_o,
    output logic              core_go_o,
    output logic              core_ch_o,
    output logic [DATA_W-1:0] hold_a_o
);
    import conv_seq_pkg::*;

    seq_state_e state_q;

    // Advance through the pair and drive all registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            busy_o    <= 1'b0;
            eoc_n_o   <= 1'b1;
            latch_o   <= 1'b0;
            core_go_o <= 1'b0;
            core_ch_o <= 1'b0;
            hold_a_o  <= '0;
        end else begin
            eoc_n_o   <= 1'b1;
            latch_o   <= 1'b0;
            core_go_o <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i && !pdown_i) begin
                        state_q   <= SEQ_CONV_A;
                        busy_o    <= 1'b1;
                        core_go_o <= 1'b1;
                        core_ch_o <= 1'b0;
                    end
                end
                SEQ_CONV_A: begin
                    if (core_done_i) begin
                        hold_a_o  <= core_res_i;
                        eoc_n_o   <= 1'b0;
                        core_go_o <= 1'b1;
                        core_ch_o <= 1'b1;
                        state_q   <= SEQ_CONV_B;
                    end
                end
                SEQ_CONV_B: begin
                    if (core_done_i) begin
                        eoc_n_o <= 1'b0;
                        latch_o <= 1'b1;
                        state_q <= SEQ_COMMIT;
                    end
                end
                SEQ_COMMIT: begin
                    busy_o  <= 1'b0;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |=> eoc_n_o); // R4
    AST_EOC_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n_o |-> busy_o); // R4
    AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && pdown_i) |=> !busy_o); // R6
    AST_LATCH_THEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |=> !busy_o); // R10
    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        core_done_i |-> busy_o); // R8
endmodule

// File: rtl/conv_result_reg.sv
// Output word register: loads both channel results on the latch strobe and
// holds them otherwise. Slot 0 (channel A) sits in the upper half.
// Assumes: load_i is a single-cycle strobe.
module conv_result_reg #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [2*DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] in_slot [conv_seq_pkg::NUM_CH];
    logic [DATA_W-1:0] slot_q  [conv_seq_pkg::NUM_CH];

    assign in_slot[0] = a_i;
    assign in_slot[1] = b_i;

    // One holding register per channel slot.
    generate
        for (genvar g = 0; g < conv_seq_pkg::NUM_CH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) slot_q[g] <= '0;
                else if (load_i) slot_q[g] <= in_slot[g];
            end
        end
    endgenerate

    assign word_o = {slot_q[0], slot_q[1]};
endmodule

// File: rtl/conv_pair_sequencer.sv
// Top level: pair sequencer, converter core stub and output word register.
// Assumes: samples are stable while busy_o is high.
module conv_pair_sequencer #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                pdown_i,
    input  logic [DATA_W-1:0]   samp_a_i,
    input  logic [DATA_W-1:0]   samp_b_i,
    output logic                busy_o,
    output logic                eoc_n_o,
    output logic                latch_o,
    output logic                core_go_o,
    output logic                core_ch_o,
    output logic [2*DATA_W-1:0] result_o
);
    logic              core_done;
    logic [DATA_W-1:0] core_res;
    logic [DATA_W-1:0] hold_a;

    conv_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pdown_i(pdown_i),
        .core_done_i(core_done), .core_res_i(core_res),
        .busy_o(busy_o), .eoc_n_o(eoc_n_o), .latch_o(latch_o),
        .core_go_o(core_go_o), .core_ch_o(core_ch_o), .hold_a_o(hold_a)
    );

    conv_core_stub #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .go_i(core_go_o), .ch_i(core_ch_o),
        .samp_a_i(samp_a_i), .samp_b_i(samp_b_i),
        .done_o(core_done), .res_o(core_res)
    );

    conv_result_reg #(.DATA_W(DATA_W)) u_word (
        .clk(clk), .rst_n(rst_n), .load_i(latch_o),
        .a_i(hold_a), .b_i(core_res), .word_o(result_o)
    );
endmodule

// File: tb/tb_conv_pair_sequencer.sv
`timescale 1ns/1ps
module tb_conv_pair_sequencer;
    localparam int W = 16;
    localparam int C = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic pdown_i = 1'b0;
    logic [W-1:0] samp_a_i = '0;
    logic [W-1:0] samp_b_i = '0;
    logic busy_o, eoc_n_o, latch_o, core_go_o, core_ch_o;
    logic [2*W-1:0] result_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    conv_pair_sequencer #(.DATA_W(W), .CONV_CYCLES(C)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pdown_i(pdown_i),
        .samp_a_i(samp_a_i), .samp_b_i(samp_b_i), .busy_o(busy_o),
        .eoc_n_o(eoc_n_o), .latch_o(latch_o), .core_go_o(core_go_o),
        .core_ch_o(core_ch_o), .result_o(result_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pulse start, then observe one window; k counts negedges after edge 0 (k=1).
    task automatic run_window(input int inj_k, input int pd_k,
                              output int busy_len, output int first_busy,
                              output int eoc_cnt, output int eoc1, output int eoc2,
                              output int latch_k, output bit go_a,
                              output logic [2*W-1:0] res_before,
                              output logic [2*W-1:0] res_after);
        busy_len = 0; first_busy = -1; eoc_cnt = 0; eoc1 = -1; eoc2 = -1;
        latch_k = -1; go_a = 1'b0; res_before = '0; res_after = '0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int k = 1; k <= 4*C + 10; k++) begin
            if (busy_o) begin
                busy_len++;
                if (first_busy < 0) first_busy = k;
            end
            if (k == 1) go_a = core_go_o && !core_ch_o;
            if (!eoc_n_o) begin
                eoc_cnt++;
                if (eoc1 < 0) eoc1 = k; else eoc2 = k;
            end
            if (latch_o) latch_k = k;
            if (k == 2*C + 5) res_before = result_o;
            if (k == 2*C + 6) res_after = result_o;
            start_i = (k == inj_k);
            if (k == pd_k) pdown_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic test_reset_state();
        check(busy_o == 1'b0, "R8", "busy after reset", busy_o, 0);
        check(eoc_n_o == 1'b1, "R8", "eoc_n after reset", eoc_n_o, 1);
        check(latch_o == 1'b0, "R8", "latch after reset", latch_o, 0);
        check(result_o == '0, "R8", "result after reset", result_o, 0);
    endtask

    task automatic test_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                             input int inj_k, input string tag);
        int bl, fb, ec, e1, e2, lk; bit ga;
        logic [2*W-1:0] rb, ra, old;
        old = result_o;
        samp_a_i = a; samp_b_i = b;
        run_window(inj_k, -1, bl, fb, ec, e1, e2, lk, ga, rb, ra);
        check(fb == 1, "R1", {tag, " busy first cycle"}, fb, 1);
        check(ga, "R1", {tag, " core go for channel A"}, ga, 1);
        check(bl == 2*C + 5, (inj_k > 0) ? "R5" : "R2", {tag, " busy length"}, bl, 2*C + 5);
        check(ec == 2, "R4", {tag, " eoc count"}, ec, 2);
        check(e1 == C + 3, "R4", {tag, " eoc A position"}, e1, C + 3);
        check(e2 == 2*C + 5, "R4", {tag, " eoc B position"}, e2, 2*C + 5);
        check(lk == 2*C + 5, "R10", {tag, " latch position"}, lk, 2*C + 5);
        check(rb == old, "R10", {tag, " word before busy fall"}, rb, old);
        check(ra == {a, b}, "R3", {tag, " word at busy fall"}, ra, {a, b});
    endtask

    task automatic test_pdown_idle();
        logic [2*W-1:0] old;
        bit seen;
        old = result_o; seen = 1'b0;
        @(negedge clk) pdown_i = 1'b1; start_i = 1'b1;
        for (int k = 0; k < 3*C; k++) begin
            @(negedge clk);
            if (busy_o || !eoc_n_o) seen = 1'b1;
        end
        start_i = 1'b0;
        check(!seen, "R6", "busy under power-down", seen, 0);
        check(result_o == old, "R6", "word under power-down", result_o, old);
        @(negedge clk) pdown_i = 1'b0;
    endtask

    task automatic test_pdown_midpair();
        int bl, fb, ec, e1, e2, lk; bit ga, seen;
        logic [2*W-1:0] rb, ra;
        samp_a_i = 16'h5A5A; samp_b_i = 16'hC3C3;
        run_window(-1, 3, bl, fb, ec, e1, e2, lk, ga, rb, ra);
        check(bl == 2*C + 5, "R7", "pair completes under power-down", bl, 2*C + 5);
        check(ra == {16'h5A5A, 16'hC3C3}, "R7", "word after power-down pair",
              ra, {16'h5A5A, 16'hC3C3});
        seen = 1'b0;
        @(negedge clk) start_i = 1'b1;
        for (int k = 0; k < 2*C; k++) begin
            @(negedge clk);
            if (busy_o) seen = 1'b1;
        end
        start_i = 1'b0;
        check(!seen, "R7", "restart refused while powered down", seen, 0);
        @(negedge clk) pdown_i = 1'b0;
    endtask

    task automatic test_back_to_back();
        int fall_k, rise_k;
        fall_k = -1; rise_k = -1;
        samp_a_i = 16'h0F0F; samp_b_i = 16'hF0F0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 3*C; k++) begin
            if (!busy_o && fall_k < 0) fall_k = k;
            if (busy_o && fall_k > 0 && rise_k < 0) rise_k = k;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(fall_k == 2*C + 6, "R9", "first busy fall", fall_k, 2*C + 6);
        check(rise_k == 2*C + 7, "R9", "second busy rise", rise_k, 2*C + 7);
        repeat (3*C) @(negedge clk);
        check(!busy_o, "R9", "idle after held start released", busy_o, 0);
    endtask

    task automatic test_reset_abort();
        bit seen;
        seen = 1'b0;
        samp_a_i = 16'h1111; samp_b_i = 16'h2222;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o, "R8", "busy after mid-pair reset", busy_o, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3*C; k++) begin
            @(negedge clk);
            if (!eoc_n_o || latch_o || busy_o) seen = 1'b1;
        end
        check(!seen, "R8", "no strobe after abort", seen, 0);
        check(result_o == '0, "R8", "word cleared by abort", result_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_pair(16'h1234, 16'hABCD, -1, "pattern1");
        test_pair(16'hFFFF, 16'h0000, -1, "pattern2");
        test_pair(16'h0000, 16'hFFFF, -1, "pattern3");
        test_pair(16'h7E81, 16'h0101, 5, "early start R5");
        test_pair(16'h3C3C, 16'h9999, 2*C + 5, "last-cycle start R5");
        test_pdown_idle();
        test_pdown_midpair();
        test_back_to_back();
        test_reset_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule